// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

This block is a vector datapath that multiplies two packed integer operands element by element and adds the products, in groups of four adjacent elements, into a wider accumulator lane. In byte mode, four 8-bit element products are summed into each 32-bit lane. In halfword mode, four 16-bit element products are summed into each 64-bit lane. A signedness control picks sign or zero extension of the elements.

An active-length input gives how many bytes of the vector take part. Every result byte at or above that length is driven to zero. Operands are captured on a valid strobe, and the updated accumulator is returned one clock later with its own valid flag.

Top module: `dotp_acc`

## Requirements
- R1: With `size_i`=0 (byte elements), the 32-bit lane i of `result_o` equals `acc_i` lane i plus the sum over k=0..3 of `src_a_i` byte (4i+k) times `src_b_i` byte (4i+k). Byte j occupies bits [8j+7:8j].
- R2: With `size_i`=1 (halfword elements), the 64-bit lane i of `result_o` equals `acc_i` lane i plus the sum over k=0..3 of halfword products (4i+k). The products are formed at full precision, so a sum above 2^32 is kept intact. Halfword j occupies bits [16j+15:16j].
- R3: With `unsigned_i`=1, elements are zero-extended before multiplication. With `unsigned_i`=0, they are sign-extended.
- R4: The element width and the lane width follow `size_i`: 0 selects bytes into 32-bit lanes, and 1 selects halfwords into 64-bit lanes.
- R5: Every result byte whose index is at or above `act_bytes_i` is zero. `act_bytes_i` must be a non-zero multiple of 16 that does not exceed the vector size in bytes.
- R6: Lane sums wrap modulo the lane width. There is no saturation and no flag.
- R7: `out_valid_o` is high in exactly the cycle after each cycle in which `in_valid_i` is high. `result_o` carries that operation's result while `out_valid_o` is high.
- R8: While `rst_ni` is low, `out_valid_o` and `result_o` are zero.
- R9: `result_o` holds its value through cycles in which `in_valid_i` is low.
- R10: When `act_bytes_i` equals the full vector size in bytes, no byte is cleared and every lane is updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Captures the operands this cycle |
| size_i | input | 1 | Element size: 0 byte, 1 halfword |
| unsigned_i | input | 1 | 1 zero-extends elements, 0 sign-extends them |
| act_bytes_i | input | $clog2(VEC_W/8)+1 | Active length in bytes |
| src_a_i | input | VEC_W | First packed multiplicand |
| src_b_i | input | VEC_W | Second packed multiplicand |
| acc_i | input | VEC_W | Accumulator vector |
| out_valid_o | output | 1 | Result valid |
| result_o | output | VEC_W | Updated accumulator, tail cleared |

## Verification
Two things can happen to the same operation in one cycle: lane wraparound in the accumulate, and clearing of the tail. The bench provokes this by issuing extreme products onto an all-ones accumulator with only half the vector active. It then checks that the lower lanes hold the wrapped sums and that the upper half reads zero, compared against a bench model. Back-to-back issues also overlap the capture of a new operation with the presentation of the previous one. Each output is checked in the cycle it is due.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
  typedef enum logic {
    ELEM_BYTE = 1'b0,
    ELEM_HALF = 1'b1
  } elem_e;

  localparam int unsigned TERMS     = 4;
  localparam int unsigned BYTE_EW   = 8;
  localparam int unsigned HALF_EW   = 16;
  localparam int unsigned BYTE_DW   = 32;
  localparam int unsigned HALF_DW   = 64;
  localparam int unsigned ACT_QUANT = 16;
endpackage

// File: rtl/dotp_quad.sv
// One destination lane: acc + sum of four extended element products.
module dotp_quad #(
  parameter int unsigned EW = 8,
  parameter int unsigned DW = 32
) (
  input  logic [4*EW-1:0] a_i,
  input  logic [4*EW-1:0] b_i,
  input  logic [DW-1:0]   acc_i,
  input  logic            uns_i,
  output logic [DW-1:0]   sum_o
);
  localparam int unsigned PW = 2*EW + 2;

  logic signed [EW:0]   xa [4];
  logic signed [EW:0]   xb [4];
  logic signed [PW-1:0] pr [4];

  always_comb begin
    sum_o = acc_i;
    for (int k = 0; k < 4; k++) begin
      xa[k] = {~uns_i & a_i[EW*k+EW-1], a_i[EW*k +: EW]};
      xb[k] = {~uns_i & b_i[EW*k+EW-1], b_i[EW*k +: EW]};
      pr[k] = xa[k] * xb[k];
      sum_o = sum_o + {{(DW-PW){pr[k][PW-1]}}, pr[k]};
    end
  end
endmodule

// File: rtl/dotp_byte_keep.sv
module dotp_byte_keep #(
  parameter int unsigned NBYTES = 32,
  parameter int unsigned AW     = $clog2(NBYTES) + 1
) (
  input  logic [AW-1:0]     act_i,
  output logic [NBYTES-1:0] keep_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign keep_o[b] = AW'(b) < act_i;
  end
endmodule

// File: rtl/dotp_acc.sv
module dotp_acc
  import dotp_pkg::*;
#(
  parameter int unsigned VEC_W  = 256,
  parameter int unsigned NBYTES = VEC_W / 8,
  parameter int unsigned AW     = $clog2(NBYTES) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             size_i,
  input  logic             unsigned_i,
  input  logic [AW-1:0]    act_bytes_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  input  logic [VEC_W-1:0] acc_i,
  output logic             out_valid_o,
  output logic [VEC_W-1:0] result_o
);
  localparam int unsigned NB_LANES = VEC_W / BYTE_DW;
  localparam int unsigned NH_LANES = VEC_W / HALF_DW;

  logic [VEC_W-1:0]  byte_res, half_res, sel_res, masked;
  logic [NBYTES-1:0] keep;

  for (genvar i = 0; i < NB_LANES; i++) begin : g_bl
    dotp_quad #(.EW(BYTE_EW), .DW(BYTE_DW)) u_q (
      .a_i   (src_a_i[i*BYTE_DW +: BYTE_DW]),
      .b_i   (src_b_i[i*BYTE_DW +: BYTE_DW]),
      .acc_i (acc_i[i*BYTE_DW +: BYTE_DW]),
      .uns_i (unsigned_i),
      .sum_o (byte_res[i*BYTE_DW +: BYTE_DW])
    );
  end

  for (genvar i = 0; i < NH_LANES; i++) begin : g_hl
    dotp_quad #(.EW(HALF_EW), .DW(HALF_DW)) u_q (
      .a_i   (src_a_i[i*HALF_DW +: HALF_DW]),
      .b_i   (src_b_i[i*HALF_DW +: HALF_DW]),
      .acc_i (acc_i[i*HALF_DW +: HALF_DW]),
      .uns_i (unsigned_i),
      .sum_o (half_res[i*HALF_DW +: HALF_DW])
    );
  end

  dotp_byte_keep #(.NBYTES(NBYTES), .AW(AW)) u_keep (
    .act_i  (act_bytes_i),
    .keep_o (keep)
  );

  assign sel_res = (elem_e'(size_i) == ELEM_HALF) ? half_res : byte_res;

  for (genvar b = 0; b < NBYTES; b++) begin : g_mask
    assign masked[8*b +: 8] = keep[b] ? sel_res[8*b +: 8] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) result_o <= masked;
    end
  end

  AST_ACT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> (act_bytes_i % ACT_QUANT == 0 && act_bytes_i != 0 && act_bytes_i <= NBYTES)); // R5
  AST_VALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R7
  AST_VALID_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(result_o)); // R9

  for (genvar b = 0; b < NBYTES; b++) begin : g_tail_chk
    AST_TAIL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && act_bytes_i <= AW'(b)) |=> (result_o[8*b +: 8] == 8'h00)); // R5
  end
endmodule

// File: tb/sim_dotp_acc.sv
`timescale 1ns/1ps
module sim_dotp_acc;
  localparam int VW = 256;
  localparam int NB = VW / 8;
  localparam int AW = $clog2(NB) + 1;

  logic clk = 1'b0, rst_ni = 1'b0, in_valid = 1'b0, size = 1'b0, uns = 1'b0;
  logic [AW-1:0] act = AW'(NB);
  logic [VW-1:0] a = '0, b = '0, acc = '0;
  logic out_valid;
  logic [VW-1:0] result;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dotp_acc #(.VEC_W(VW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .size_i(size),
    .unsigned_i(uns), .act_bytes_i(act), .src_a_i(a), .src_b_i(b), .acc_i(acc),
    .out_valid_o(out_valid), .result_o(result)
  );

  function automatic logic [VW-1:0] ref_dot(logic [VW-1:0] fa, logic [VW-1:0] fb,
      logic [VW-1:0] facc, bit fsz, bit funs, int fact);
    logic [VW-1:0] r = '0;
    int nl = fsz ? VW/64 : VW/32;
    for (int i = 0; i < nl; i++) begin
      logic [63:0] s = fsz ? facc[64*i +: 64] : {32'h0, facc[32*i +: 32]};
      for (int k = 0; k < 4; k++) begin
        int e = 4*i + k;
        longint x, y;
        if (fsz) begin
          x = funs ? longint'(fa[16*e +: 16]) : longint'($signed(fa[16*e +: 16]));
          y = funs ? longint'(fb[16*e +: 16]) : longint'($signed(fb[16*e +: 16]));
        end else begin
          x = funs ? longint'(fa[8*e +: 8]) : longint'($signed(fa[8*e +: 8]));
          y = funs ? longint'(fb[8*e +: 8]) : longint'($signed(fb[8*e +: 8]));
        end
        s = s + 64'(x * y);
      end
      if (fsz) r[64*i +: 64] = s;
      else     r[32*i +: 32] = s[31:0];
    end
    for (int j = 0; j < NB; j++) if (j >= fact) r[8*j +: 8] = 8'h00;
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int w = 0; w < VW/32; w++) v[32*w +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(string req, logic [VW-1:0] got, logic [VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_bit(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // Drive at negedge, sample the registered result at the next negedge.
  task automatic issue(string req, logic [VW-1:0] ia, logic [VW-1:0] ib,
      logic [VW-1:0] iacc, bit isz, bit iuns, int iact);
    @(negedge clk);
    a = ia; b = ib; acc = iacc; size = isz; uns = iuns; act = AW'(iact);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit({req, " R7 valid"}, out_valid, 1'b1);
    chk(req, result, ref_dot(ia, ib, iacc, isz, iuns, iact));
  endtask

  logic done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] prev, e1, e2, ra1, rb1, rc1, ra2, rb2, rc2;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk_bit("R8 valid in reset", out_valid, 1'b0);
    chk("R8 result in reset", result, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_bit("R8 valid after reset", out_valid, 1'b0);

    // R1 R3 signed byte extremes: -128*-128 four times
    issue("R1 R3 byte signed -128", {NB{8'h80}}, {NB{8'h80}}, '0, 1'b0, 1'b0, NB);
    // R1 R3 unsigned byte extremes 255*255
    issue("R1 R3 byte unsigned 255", {NB{8'hFF}}, {NB{8'hFF}}, {(VW/32){32'h0000_1234}}, 1'b0, 1'b1, NB);
    // R3 same bits signed: -1*-1
    issue("R3 byte signed -1", {NB{8'hFF}}, {NB{8'hFF}}, '0, 1'b0, 1'b0, NB);
    // R2 halfword extremes exceeding 32 bits
    issue("R2 R3 half signed -32768", {(NB/2){16'h8000}}, {(NB/2){16'h8000}}, '0, 1'b1, 1'b0, NB);
    issue("R2 R3 half unsigned 65535", {(NB/2){16'hFFFF}}, {(NB/2){16'hFFFF}}, '0, 1'b1, 1'b1, NB);
    // R6 wrap on all-ones accumulator, R5 tail cleared in same op
    issue("R6 R5 byte wrap with tail", {NB{8'h80}}, {NB{8'h80}}, {VW{1'b1}}, 1'b0, 1'b0, 16);
    issue("R6 half wrap", {(NB/2){16'hFFFF}}, {(NB/2){16'hFFFF}}, {VW{1'b1}}, 1'b1, 1'b1, NB);
    // R4 same operands, both sizes
    ra1 = rnd_vec(); rb1 = rnd_vec(); rc1 = rnd_vec();
    issue("R4 size byte", ra1, rb1, rc1, 1'b0, 1'b0, NB);
    issue("R4 size half", ra1, rb1, rc1, 1'b1, 1'b0, NB);
    // R5 tail in halfword mode, R10 full length
    issue("R5 half tail", ra1, rb1, rc1, 1'b1, 1'b1, 16);
    issue("R10 full length", ra1, rb1, {VW{1'b1}}, 1'b1, 1'b0, NB);

    // R9 hold: inputs change with in_valid low
    prev = result;
    @(negedge clk);
    a = rnd_vec(); b = rnd_vec(); acc = rnd_vec(); size = ~size;
    @(negedge clk);
    chk("R9 hold", result, prev);
    chk_bit("R7 no valid without issue", out_valid, 1'b0);

    // R7 back-to-back issue
    ra1 = rnd_vec(); rb1 = rnd_vec(); rc1 = rnd_vec();
    ra2 = rnd_vec(); rb2 = rnd_vec(); rc2 = rnd_vec();
    e1 = ref_dot(ra1, rb1, rc1, 1'b0, 1'b1, NB);
    e2 = ref_dot(ra2, rb2, rc2, 1'b1, 1'b0, 16);
    @(negedge clk);
    a = ra1; b = rb1; acc = rc1; size = 1'b0; uns = 1'b1; act = AW'(NB); in_valid = 1'b1;
    @(negedge clk);
    chk("R7 back-to-back first", result, e1);
    a = ra2; b = rb2; acc = rc2; size = 1'b1; uns = 1'b0; act = AW'(16);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 back-to-back second", result, e2);
    chk_bit("R7 valid held", out_valid, 1'b1);

    // Random mix across all variants
    for (int t = 0; t < 60; t++) begin
      bit rs = 1'($urandom);
      bit ru = 1'($urandom);
      int ract = ($urandom % 2) ? NB : 16;
      issue(rs ? "R2 R3 R5 random half" : "R1 R3 R5 random byte",
            rnd_vec(), rnd_vec(), rnd_vec(), rs, ru, ract);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule